// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device-side command interpreter of a parallel NOR flash. It watches asynchronous-style bus cycles (chip enable, write enable, output enable, address, 16-bit data) after sampling them on a system clock. It recognises two-write unlock preambles and the commands that follow them: silicon-ID entry, a six-write chip erase and a return-to-read reset. The outcome decides what a read returns: array contents, identification codes, or erase status.

The memory array is modelled as a small register file that is loaded with a fixed pattern at reset. A chip erase runs an internal timer for a parameterised number of clocks. While it runs, reads return a status word with a toggling bit, a done bit and a time-limit bit. A test input forces the time-limit failure path. A byte/word input narrows every read to the low byte.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, and word i of the 16-word array reads `(16'h3C00 ^ (i * 16'h0111))` truncated to 16 bits, where i is taken from the low four address bits.
- R2: The unlock preamble is data 00AAH at address 555H followed by data 0055H at address 2AAH. Addresses are compared over the full address bus, and data is compared over all 16 bits. Any write that does not match the expected step discards the sequence and selects array-read mode.
- R3: The preamble followed by 0090H at 555H selects ID mode. ID mode persists over any number of reads until a write of 00F0H, after which array data is returned again.
- R4: In ID mode, a read with address bits 1:0 = 00 returns 00C2H.
- R5: In ID mode, a read with address bits 1:0 = 01 returns 2251H when parameter TOP_BOOT is 1, and 2257H otherwise.
- R6: In ID mode, a read with address bit 1 = 1 returns 0001H if the sector given by the two top address bits has its bit set in PROT_MAP, and 0000H if not.
- R7: Chip erase is the preamble, 0080H at 555H, the preamble again, then 0010H at 555H. It starts on the clock that samples the rising write-enable edge of the last write. From then on, reads return status with bit 7 = 0.
- R8: The status word has bit 6 toggling after every completed read, bit 7 = 0 and bit 5 = time-limit failure. All other bits are 0.
- R9: An erase that does not fail completes ERASE_CYCLES clocks after it starts. It then sets every array word to FFFFH and returns to array-read mode.
- R10: While an erase is running and has not failed, all writes are ignored, including 00F0H.
- R11: A high force_timeout during a running erase sets status bit 5 and stops the erase. Status stays selected until a 00F0H write, which returns to array reads with the array unchanged.
- R12: With wide = 0 (byte mode), every read returns 00H in bits 15:8 and the low byte of the word-mode value in bits 7:0.
- R13: dout is 0000H whenever ce_n or oe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| wide | input | 1 | 1 = word reads, 0 = byte reads |
| addr | input | ADDR_W (17) | Word address |
| din | input | 16 | Write data |
| force_timeout | input | 1 | Test input forcing erase time-limit failure |
| dout | output | 16 | Read data |

## Verification
Random array reads at random addresses, in both widths, show that the reset pattern and the byte narrowing are right for every word. Correct preambles are mixed with sequences that break at each step: wrong data, wrong address, or an unknown command after the preamble. These show whether a broken sequence really falls back to array reads, and whether a near-miss erase leaves the array intact. Erase runs that complete are kept apart from erase runs that are forced to fail. This separates the done and fill path from the sticky failure path. Writes issued during the run tell an ignoring decoder from one that aborts early.

// File: rtl/flash_cmd_pkg.sv
// Package: shared read-mode and sequencer state types plus command constants
// for the flash command decoder. Assumes 16-bit data words.
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_ID     = 2'd1,
        RM_STATUS = 2'd2
    } rmode_t;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_U1    = 3'd1,
        SQ_U2    = 3'd2,
        SQ_SETUP = 3'd3,
        SQ_EU1   = 3'd4,
        SQ_EU2   = 3'd5
    } seq_t;

    localparam logic [15:0] CMD_KEY_A   = 16'h00AA;
    localparam logic [15:0] CMD_KEY_B   = 16'h0055;
    localparam logic [15:0] CMD_ID      = 16'h0090;
    localparam logic [15:0] CMD_ARM     = 16'h0080;
    localparam logic [15:0] CMD_WIPE    = 16'h0010;
    localparam logic [15:0] CMD_RESET   = 16'h00F0;
    localparam int unsigned ADR_KEY_A   = 32'h555;
    localparam int unsigned ADR_KEY_B   = 32'h2AA;
    localparam logic [15:0] MFR_CODE    = 16'h00C2;
    localparam logic [15:0] DEV_TOP     = 16'h2251;
    localparam logic [15:0] DEV_BOTTOM  = 16'h2257;

endpackage

// File: rtl/flash_cmd_seq.sv
// Module: flash_cmd_seq
// Walks the unlock / command write sequence and holds the read mode.
// Assumes wr_stb is a one-clock pulse per completed bus write.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              erase_busy,
    input  logic              erase_fail,
    input  logic              erase_done,
    output rmode_t            rmode,
    output logic              erase_start,
    output logic              erase_abort
);

    localparam logic [ADDR_W-1:0] A_KEY_A = ADDR_W'(ADR_KEY_A);
    localparam logic [ADDR_W-1:0] A_KEY_B = ADDR_W'(ADR_KEY_B);

    seq_t state;
    logic at_a, at_b, is_reset;

    // Address and data classification of the current write.
    always_comb begin
        at_a     = (wr_addr == A_KEY_A);
        at_b     = (wr_addr == A_KEY_B);
        is_reset = (wr_data == CMD_RESET);
    end

    // Erase launch and abort strobes toward the timer.
    always_comb begin
        erase_start = wr_stb && (rmode != RM_STATUS) && !is_reset &&
                      (state == SQ_EU2) && at_a && (wr_data == CMD_WIPE);
        erase_abort = wr_stb && (rmode == RM_STATUS) && erase_fail && is_reset;
    end

    // Sequence state and read-mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            rmode <= RM_ARRAY;
        end else if (erase_done) begin
            state <= SQ_IDLE;
            rmode <= RM_ARRAY;
        end else if (rmode == RM_STATUS) begin
            if (erase_abort) begin
                rmode <= RM_ARRAY;
            end
            state <= SQ_IDLE;
        end else if (wr_stb) begin
            if (is_reset) begin
                state <= SQ_IDLE;
                rmode <= RM_ARRAY;
            end else begin
                state <= SQ_IDLE;
                rmode <= RM_ARRAY;
                case (state)
                    SQ_IDLE: if (at_a && wr_data == CMD_KEY_A) begin
                        state <= SQ_U1;
                        rmode <= rmode;
                    end
                    SQ_U1: if (at_b && wr_data == CMD_KEY_B) begin
                        state <= SQ_U2;
                        rmode <= rmode;
                    end
                    SQ_U2: if (at_a && wr_data == CMD_ID) begin
                        rmode <= RM_ID;
                    end else if (at_a && wr_data == CMD_ARM) begin
                        state <= SQ_SETUP;
                        rmode <= rmode;
                    end
                    SQ_SETUP: if (at_a && wr_data == CMD_KEY_A) begin
                        state <= SQ_EU1;
                        rmode <= rmode;
                    end
                    SQ_EU1: if (at_b && wr_data == CMD_KEY_B) begin
                        state <= SQ_EU2;
                        rmode <= rmode;
                    end
                    SQ_EU2: if (at_a && wr_data == CMD_WIPE) begin
                        rmode <= RM_STATUS;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: the timer runs only while status reads are selected.
    p_busy_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> (rmode == RM_STATUS));

    // R7: status mode is only entered by a completed write.
    p_status_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rmode == RM_STATUS) && ($past(rmode) != RM_STATUS) |-> $past(wr_stb));

endmodule

// File: rtl/flash_erase_timer.sv
// Module: flash_erase_timer
// Models the self-timed erase with a cycle counter; a forced timeout
// latches a failure that only an abort clears.
module flash_erase_timer #(
    parameter int ERASE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic force_timeout,
    output logic busy,
    output logic fail,
    output logic done
);

    localparam int CNT_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Completion pulse on the last counted clock of a healthy run.
    always_comb begin
        done = busy && !fail && !force_timeout && (cnt == LAST);
    end

    // Run, fail and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            fail <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            fail <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (abort) begin
                busy <= 1'b0;
                fail <= 1'b0;
            end else if (!fail) begin
                if (force_timeout) begin
                    fail <= 1'b1;
                end else if (done) begin
                    busy <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R11: a failure persists until an abort arrives.
    p_fail_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !abort && !start |=> fail);

    // R9: the counter never runs past the configured length.
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/flash_array.sv
// Module: flash_array
// Small register-file stand-in for the memory array: loaded with a fixed
// pattern at reset, filled with all ones on an erase completion.
module flash_array #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [15:0]                rd_word
);

    logic [15:0] mem [DEPTH];

    // Reset pattern and erase fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 16'h3C00 ^ 16'(i * 16'h0111);
            end
        end else if (clear) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 16'hFFFF;
            end
        end
    end

    // Asynchronous read port.
    always_comb begin
        rd_word = mem[rd_idx];
    end

    // R9: a completed erase leaves both ends of the array at all ones.
    p_erase_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mem[0] == 16'hFFFF) && (mem[DEPTH-1] == 16'hFFFF));

endmodule

// File: rtl/flash_read_mux.sv
// Module: flash_read_mux
// Picks array data, ID codes or the erase status word for the data bus,
// narrows to a byte when requested and blanks the bus when not reading.
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  rmode_t      rmode,
    input  logic [1:0]  id_sel,
    input  logic        prot_bit,
    input  logic        wide,
    input  logic        toggle,
    input  logic        fail,
    input  logic        active,
    input  logic [15:0] array_word,
    output logic [15:0] dout
);

    localparam logic [15:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOTTOM;

    logic [15:0] word_val;

    // Source selection by read mode.
    always_comb begin
        case (rmode)
            RM_ID: begin
                if (id_sel[1])       word_val = {15'd0, prot_bit};
                else if (id_sel[0])  word_val = DEV_CODE;
                else                 word_val = MFR_CODE;
            end
            RM_STATUS: word_val = {8'h00, 1'b0, toggle, fail, 5'b00000};
            default:   word_val = array_word;
        endcase
    end

    // Width narrowing and bus blanking.
    always_comb begin
        if (!active)    dout = 16'h0000;
        else if (wide)  dout = word_val;
        else            dout = {8'h00, word_val[7:0]};
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Module: flash_cmd_ctrl (top)
// Parallel flash command decoder. Samples the bus strobes on clk, turns the
// write-enable rising edge into a write strobe and the output-enable rising
// edge into a read-complete strobe, and ties the sequencer, erase timer,
// array model and read mux together. Assumes bus strobes are held stable
// for at least one clock on each level.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W       = 17,
    parameter int          DEPTH        = 16,
    parameter int          SECTORS      = 4,
    parameter logic [3:0]  PROT_MAP     = 4'b0101,
    parameter bit          TOP_BOOT     = 1'b1,
    parameter int          ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    input  logic              force_timeout,
    output logic [15:0]       dout
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int SEC_W = $clog2(SECTORS);

    logic        we_q, oe_q, wr_stb, rd_done, toggle;
    logic        erase_start, erase_abort, erase_busy, erase_fail, erase_done;
    logic [15:0] array_word;
    logic [SEC_W-1:0] sector;
    logic        prot_bit;
    rmode_t      rmode;

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            oe_q <= 1'b1;
        end else begin
            we_q <= we_n;
            oe_q <= oe_n;
        end
    end

    // Write and read-complete strobes.
    always_comb begin
        wr_stb  = !ce_n && we_n && !we_q;
        rd_done = !ce_n && oe_n && !oe_q;
    end

    // Status toggle bit flips after each completed status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                               toggle <= 1'b0;
        else if (rd_done && rmode == RM_STATUS)   toggle <= !toggle;
    end

    // Sector protection lookup from the top address bits.
    always_comb begin
        sector   = addr[ADDR_W-1 -: SEC_W];
        prot_bit = PROT_MAP[sector];
    end

    flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_addr    (addr),
        .wr_data    (din),
        .erase_busy (erase_busy),
        .erase_fail (erase_fail),
        .erase_done (erase_done),
        .rmode      (rmode),
        .erase_start(erase_start),
        .erase_abort(erase_abort)
    );

    flash_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (erase_start),
        .abort        (erase_abort),
        .force_timeout(force_timeout),
        .busy         (erase_busy),
        .fail         (erase_fail),
        .done         (erase_done)
    );

    flash_array #(.DEPTH(DEPTH)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (erase_done),
        .rd_idx (addr[IDX_W-1:0]),
        .rd_word(array_word)
    );

    flash_read_mux #(.TOP_BOOT(TOP_BOOT)) u_mux (
        .rmode     (rmode),
        .id_sel    (addr[1:0]),
        .prot_bit  (prot_bit),
        .wide      (wide),
        .toggle    (toggle),
        .fail      (erase_fail),
        .active    (!ce_n && !oe_n),
        .array_word(array_word),
        .dout      (dout)
    );

    // R8: the toggle bit changes on every completed status read.
    p_toggle_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && (rmode == RM_STATUS) |=> toggle != $past(toggle));

    // R10: a healthy running erase is not cut short by bus writes.
    p_no_early_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy && !erase_fail && !erase_done |=> erase_busy);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

    localparam int ADDR_W = 17;
    localparam int LIMIT  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wide = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       din = '0;
    logic              force_timeout = 1'b0;
    logic [15:0]       dout;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wide(wide), .addr(addr), .din(din), .force_timeout(force_timeout),
        .dout(dout)
    );

    function automatic logic [15:0] init_word(input int i);
        return 16'h3C00 ^ 16'(i * 16'h0111);
    endfunction

    function automatic logic [15:0] narrow(input logic [15:0] w, input logic wd);
        return wd ? w : {8'h00, w[7:0]};
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 1'b0; addr = a; din = d; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        @(negedge clk);
        ce_n = 1'b0; addr = a; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        d = dout;
        oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic unlock();
        bus_write(17'h555, 16'h00AA);
        bus_write(17'h2AA, 16'h0055);
    endtask

    task automatic erase_seq(input logic [15:0] last);
        unlock();
        bus_write(17'h555, 16'h0080);
        unlock();
        bus_write(17'h555, last);
    endtask

    task automatic check_array(input string req, input bit erased);
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin
            logic [ADDR_W-1:0] a;
            a = {$urandom_range(0, 8191), 4'(i)};
            bus_read(a, v);
            chk(req, v, narrow(erased ? 16'hFFFF : init_word(i), wide));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents, array mode
        check_array("R1", 1'b0);
        // R12: byte-wide array reads
        wide = 1'b0;
        check_array("R12", 1'b0);
        wide = 1'b1;

        // R13: bus idle while oe_n high
        @(negedge clk); ce_n = 1'b0; addr = 17'h3;
        @(negedge clk); chk("R13 oe high", dout, 16'h0000);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); chk("R13 ce high", dout, 16'h0000);
        oe_n = 1'b1;

        // R3/R4/R5/R6: ID entry and codes
        unlock();
        bus_write(17'h555, 16'h0090);
        for (int k = 0; k < 6; k++) begin
            logic [ADDR_W-1:0] a;
            a = 17'($urandom) & ~17'h3;
            bus_read(a, v);       chk("R4 mfr", v, 16'h00C2);
            bus_read(a | 17'h1, v); chk("R5 dev", v, 16'h2251);
        end
        for (int s = 0; s < 4; s++) begin
            bus_read({2'(s), 15'h0002}, v);
            chk("R6 prot", v, (s == 0 || s == 2) ? 16'h0001 : 16'h0000);
            bus_read({2'(s), 15'h1233}, v);
            chk("R6 prot", v, (s == 0 || s == 2) ? 16'h0001 : 16'h0000);
        end
        wide = 1'b0;
        bus_read(17'h0, v); chk("R12 mfr byte", v, 16'h00C2);
        bus_read(17'h1, v); chk("R12 dev byte", v, 16'h0051);
        wide = 1'b1;
        bus_read(17'h0, v); chk("R3 id persists", v, 16'h00C2);
        bus_write(17'h0, 16'h00F0);
        check_array("R3 after reset cmd", 1'b0);

        // R2: broken sequences at each step fall back to array reads
        for (int k = 0; k < 8; k++) begin
            logic [15:0] d;
            unlock();
            bus_write(17'h555, 16'h0090);       // enter ID
            case (k % 4)
                0: begin d = 16'($urandom) | 16'h0100; bus_write(17'h555, d); end
                1: begin bus_write(17'h555, 16'h00AA); bus_write(17'h2AB, 16'h0055); end
                2: begin unlock(); bus_write(17'h555, 16'h0033); end
                default: begin bus_write(17'h1555, 16'h00AA); end
            endcase
            bus_read(17'h5, v);
            chk("R2 mismatch", v, init_word(5));
        end

        // R2/R7: erase sequence broken at its last write leaves array intact
        erase_seq(16'h0030);
        repeat (LIMIT + 8) @(negedge clk);
        check_array("R2 near-miss erase", 1'b0);

        // R7/R8/R10/R11: erase that is forced to fail
        erase_seq(16'h0010);
        bus_read(17'h7, v); chk("R7 status first", v, 16'h0000);
        bus_read(17'h7, v); chk("R8 toggle", v, 16'h0040);
        bus_read(17'h7, v); chk("R8 toggle back", v, 16'h0000);
        bus_write(17'h0, 16'h00F0);
        bus_read(17'h7, v); chk("R10 write ignored", v & 16'hFFBF, 16'h0000);
        @(negedge clk); force_timeout = 1'b1;
        @(negedge clk); force_timeout = 1'b0;
        bus_read(17'h2, v); chk("R11 fail bit", v & 16'hFFBF, 16'h0020);
        repeat (LIMIT + 10) @(negedge clk);
        bus_read(17'h2, v); chk("R11 fail held", v & 16'hFFBF, 16'h0020);
        wide = 1'b0;
        bus_read(17'h2, v); chk("R12 status byte", v & 16'hFFBF, 16'h0020);
        wide = 1'b1;
        bus_write(17'h0, 16'h00F0);
        check_array("R11 array unchanged", 1'b0);

        // R7/R9: erase that completes
        erase_seq(16'h0010);
        bus_read(17'h9, v); chk("R7 busy status", v & 16'h00BF, 16'h0000);
        repeat (LIMIT + 5) @(negedge clk);
        check_array("R9 filled", 1'b1);
        wide = 1'b0;
        check_array("R12 filled byte", 1'b1);
        wide = 1'b1;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule